// File: doc/BRIEF.md
# Timer Event Capture and Compare Array

This block places a row of event channels beside four free-running timers that live elsewhere on the chip. Each channel reads all four timer values every cycle. A general channel works in one of two modes. In capture mode it watches its input pin for a chosen edge and stores the value of its selected timer. In compare mode it waits until its selected timer equals a stored value and then sets, clears or toggles its output pin. Compare-only channels have no input pin. When their compare fires they can also store the value of a second timer in that same cycle. This keeps a position count and a time count aligned with no software in the loop.

Every capture and every compare fire raises a one-cycle interrupt request for that channel. Software sets up channels and collects results through a small register port. No result streams out of the block: captured values wait in a register until software reads them. So the register port is a plain strobe interface with no back-pressure. A write is taken on the clock edge where `wr_en` is high. A read is taken on the edge where `rd_en` is high, and `rdata` holds the result from that edge until the next read.

Top module: `evt_array`

## Requirements
- R1: After reset every register reads zero, and all output pins, interrupt requests and `rdata` are 0.
- R2: Register address = {channel, word}. Word 0 is control, 1 is the compare value, 2 is the captured value and 3 is status. `rdata` is loaded on the edge where `rd_en` is high and holds until the next read. Control is 12 bits and upper write bits read back as 0. The control fields are: bit0 enable, bit1 mode (1 = compare), bits3:2 selected timer, bits5:4 edge (01 rising, 10 falling, 11 both, 00 none), bits7:6 action (01 set, 10 clear, 11 toggle, 00 none), bit8 re-arm, bits10:9 second timer, bit11 second-capture enable.
- R3: A compare fires when the channel is enabled, in compare mode and armed, and its selected timer equals the compare value. The output pin takes the selected action on that same edge.
- R4: In capture mode the pin passes through two synchronizer flops. The selected timer value is stored on the third rising clock edge after the pin changes, and only for a selected edge type.
- R5: A one-cycle interrupt pulse comes on the edge that stores a capture or applies a compare action.
- R6: When a compare-only channel fires with second-capture enabled and a second timer different from its selected timer, it stores that second timer's value on the firing edge. If the two timer selections are equal, nothing is stored.
- R7: If a new value arrives while an earlier one is still unread, the earlier value is kept and status bit1 (overrun) is set.
- R8: Writing the compare value arms the channel (status bit2). A fire disarms the channel unless re-arm is set. With re-arm set, the channel fires on every cycle of equality.
- R9: Compare-only channels ignore the mode bit and always compare.
- R10: Reading the captured value clears status bit0 (full). Reading status clears overrun.
- R11: A channel with enable at 0 raises no event and leaves its pin unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 4*TW | Four timer values, timer 0 in the low bits |
| evt_in | input | N_GEN | Capture pins of the general channels |
| evt_out | output | N_GEN+N_CMP | Compare output pins |
| irq | output | N_GEN+N_CMP | Per-channel event pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | clog2(N_GEN+N_CMP)+2 | Channel and word select |
| wdata | input | TW | Write data |
| rdata | output | TW | Read data |

## Verification
A compare result is due one edge after the cycle in which the timer bus equals the compare value. The output pin, the interrupt and any second capture all appear together on that edge. A capture result is due three edges after the pin change. A read result is due one edge after the strobe. The bench keeps a free-running edge counter. For each stimulus it queues the exact counter value at which the interrupt must appear, and the monitor compares against that value at every falling edge. Values and pins are sampled one half cycle after the edge that updates them.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int TMR_N  = 4;
  localparam int TSEL_W = $clog2(TMR_N);

  typedef enum logic [1:0] {EDGE_NONE, EDGE_RISE, EDGE_FALL, EDGE_BOTH} edge_e;
  typedef enum logic [1:0] {ACT_NONE, ACT_SET, ACT_CLR, ACT_TGL} act_e;

  typedef struct packed {
    logic              sim_en;
    logic [TSEL_W-1:0] sim_sel;
    logic              rearm;
    act_e              act;
    edge_e             edg;
    logic [TSEL_W-1:0] tsel;
    logic              mode;
    logic              en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det
  import evt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pin,
  input  edge_e sel,
  output logic  hit
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  logic rise, fall;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  // R4: a selected edge is only reported as a change between two synchronized stages
  assert_hit_needs_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (s2 != s3));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_pkg::*;
#(
  parameter int TW     = 16,
  parameter int CAP_OK = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TMR_N*TW-1:0] tmr_i,
  input  logic                pin,
  input  logic                ctrl_wr,
  input  logic                cmp_wr,
  input  logic [TW-1:0]       wdata,
  input  logic                cap_clr,
  input  logic                ovf_clr,
  output ctrl_t               ctrl_o,
  output logic [TW-1:0]       cmp_o,
  output logic [TW-1:0]       cap_o,
  output logic                full_o,
  output logic                ovf_o,
  output logic                armed_o,
  output logic                out_o,
  output logic                irq_o
);
  localparam bit HAS_PIN = (CAP_OK != 0);

  ctrl_t         ctrl;
  logic [TW-1:0] cmp_val, cap_val;
  logic          full, ovf, armed, out_q, irq_q;
  logic          edge_hit;

  generate
    if (HAS_PIN) begin : g_cap
      evt_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin),
        .sel  (ctrl.edg),
        .hit  (edge_hit)
      );
    end else begin : g_nocap
      logic unused_pin;
      assign unused_pin = pin;
      assign edge_hit   = 1'b0;
    end
  endgenerate

  logic [TW-1:0] ref_v, sec_v, latch_v;
  assign ref_v = tmr_i[ctrl.tsel*TW +: TW];
  assign sec_v = tmr_i[ctrl.sim_sel*TW +: TW];

  logic is_cmp, cap_ev, fire, sim_ev, latch_ev, held;
  assign is_cmp   = !HAS_PIN || ctrl.mode;
  assign cap_ev   = HAS_PIN && ctrl.en && !ctrl.mode && edge_hit;
  assign fire     = ctrl.en && is_cmp && armed && (ref_v == cmp_val);
  assign sim_ev   = !HAS_PIN && fire && ctrl.sim_en && (ctrl.sim_sel != ctrl.tsel);
  assign latch_ev = cap_ev || sim_ev;
  assign latch_v  = HAS_PIN ? ref_v : sec_v;
  assign held     = full && !cap_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cmp_val <= '0;
      cap_val <= '0;
      full    <= 1'b0;
      ovf     <= 1'b0;
      armed   <= 1'b0;
      out_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (cmp_wr) cmp_val <= wdata;

      if (cmp_wr)                    armed <= 1'b1;
      else if (fire && !ctrl.rearm)  armed <= 1'b0;

      if (latch_ev)     full <= 1'b1;
      else if (cap_clr) full <= 1'b0;

      if (latch_ev && !held) cap_val <= latch_v;

      if (latch_ev && held) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;

      if (fire) begin
        unique case (ctrl.act)
          ACT_SET: out_q <= 1'b1;
          ACT_CLR: out_q <= 1'b0;
          ACT_TGL: out_q <= ~out_q;
          default: out_q <= out_q;
        endcase
      end

      irq_q <= cap_ev || fire;
    end
  end

  assign ctrl_o  = ctrl;
  assign cmp_o   = cmp_val;
  assign cap_o   = cap_val;
  assign full_o  = full;
  assign ovf_o   = ovf;
  assign armed_o = armed;
  assign out_o   = out_q;
  assign irq_o   = irq_q;

  // R3: the output pin moves only on a compare fire
  assert_out_only_on_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(out_q));
  // R7: an unread value is never overwritten
  assert_keep_unread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(cap_val));
  // R7: an arrival onto an unread value flags overrun
  assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_ev && held) |=> ovf);
  // R8: without re-arm a fire is not repeated on the next cycle unless rewritten
  assert_single_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl.rearm && !cmp_wr) |=> !fire);
  // R6: second timer value lands on the firing edge
  assert_sim_same_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sim_ev && !held) |=> (cap_val == $past(sec_v)));
  // R5: every event yields an interrupt pulse
  assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire || cap_ev) |=> irq_o);
endmodule

// File: rtl/evt_array.sv
module evt_array
  import evt_pkg::*;
#(
  parameter int TW    = 16,
  parameter int N_GEN = 2,
  parameter int N_CMP = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [TMR_N*TW-1:0]                     tmr_val,
  input  logic [N_GEN-1:0]                        evt_in,
  output logic [N_GEN+N_CMP-1:0]                  evt_out,
  output logic [N_GEN+N_CMP-1:0]                  irq,
  input  logic                                    wr_en,
  input  logic                                    rd_en,
  input  logic [$clog2(N_GEN+N_CMP)+1:0]          addr,
  input  logic [TW-1:0]                           wdata,
  output logic [TW-1:0]                           rdata
);
  localparam int N_CH = N_GEN + N_CMP;
  localparam int CW   = $clog2(N_CH);
  localparam int AW   = CW + 2;

  localparam logic [1:0] W_CTRL = 2'd0;
  localparam logic [1:0] W_CMP  = 2'd1;
  localparam logic [1:0] W_CAP  = 2'd2;
  localparam logic [1:0] W_STAT = 2'd3;

  logic [CW-1:0] ch_sel;
  logic [1:0]    wsel;
  assign ch_sel = addr[AW-1:2];
  assign wsel   = addr[1:0];

  ctrl_t         ctrl_a  [N_CH];
  logic [TW-1:0] cmp_a   [N_CH];
  logic [TW-1:0] cap_a   [N_CH];
  logic [N_CH-1:0] full_v, ovf_v, armed_v, cap_clr_v;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      localparam logic [CW-1:0] MY = CW'(c);
      logic hit, pin_c;
      assign hit          = (ch_sel == MY);
      assign cap_clr_v[c] = rd_en && hit && (wsel == W_CAP);

      if (c < N_GEN) begin : g_pin
        assign pin_c = evt_in[c];
      end else begin : g_nopin
        assign pin_c = 1'b0;
      end

      evt_channel #(
        .TW    (TW),
        .CAP_OK((c < N_GEN) ? 1 : 0)
      ) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tmr_i  (tmr_val),
        .pin    (pin_c),
        .ctrl_wr(wr_en && hit && (wsel == W_CTRL)),
        .cmp_wr (wr_en && hit && (wsel == W_CMP)),
        .wdata  (wdata),
        .cap_clr(cap_clr_v[c]),
        .ovf_clr(rd_en && hit && (wsel == W_STAT)),
        .ctrl_o (ctrl_a[c]),
        .cmp_o  (cmp_a[c]),
        .cap_o  (cap_a[c]),
        .full_o (full_v[c]),
        .ovf_o  (ovf_v[c]),
        .armed_o(armed_v[c]),
        .out_o  (evt_out[c]),
        .irq_o  (irq[c])
      );
    end
  endgenerate

  logic [TW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int c = 0; c < N_CH; c++) begin
      if (ch_sel == CW'(c)) begin
        unique case (wsel)
          W_CTRL:  rd_word = TW'(ctrl_a[c]);
          W_CMP:   rd_word = cmp_a[c];
          W_CAP:   rd_word = cap_a[c];
          default: rd_word = TW'({armed_v[c], ovf_v[c], full_v[c]});
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  // R2: read data holds between reads
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R10: a single read clears at most one channel's full flag
  assert_one_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_clr_v));
endmodule

// File: tb/tb_evt_array.sv
module tb_evt_array;
  localparam int TW = 16;
  localparam int NG = 2;
  localparam int NC = 2;
  localparam int NCH = NG + NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] tmr [4];
  logic [4*TW-1:0] tmr_val;
  logic [NG-1:0] evt_in = '0;
  logic [NCH-1:0] evt_out, irq;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [TW-1:0] wdata = '0;
  logic [TW-1:0] rdata;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_ch[$];
  int exp_cyc[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tmr_val = {tmr[3], tmr[2], tmr[1], tmr[0]};

  evt_array #(.TW(TW), .N_GEN(NG), .N_CMP(NC)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val), .evt_in(evt_in),
    .evt_out(evt_out), .irq(irq), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    addr = 4'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input int a, input logic [15:0] exp, input string tag);
    addr = 4'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(tag, rdata, exp);
  endtask

  task automatic expect_irq(input int ch, input int delay);
    exp_ch.push_back(ch);
    exp_cyc.push_back(cyc + delay);
  endtask

  // scoreboard monitor: every interrupt pulse must match the queued channel and edge count
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (irq[c]) begin
          checks++;
          if (exp_ch.size() == 0) begin
            failures++;
            $display("FAIL R5 unexpected irq actual=ch%0d@%0d expected=none", c, cyc);
          end else begin
            int ec, ey;
            ec = exp_ch.pop_front();
            ey = exp_cyc.pop_front();
            if (ec != c || ey != cyc) begin
              failures++;
              $display("FAIL R5 irq actual=ch%0d@%0d expected=ch%0d@%0d", c, cyc, ec, ey);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) tmr[i] = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 evt_out", evt_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rdata", rdata, 0);
    rdchk(0, 16'h0000, "R1 ctrl ch0");
    rdchk(11, 16'h0000, "R1 status ch2");

    // R2 control readback, 12 bits kept
    wr(0, 16'hFABC);
    rdchk(0, 16'h0ABC, "R2 ctrl readback");

    // R4 rising capture on ch0 from timer1
    tmr[1] = 16'h1234;
    wr(0, 16'h0015);
    evt_in[0] = 1'b1;
    expect_irq(0, 3);
    tick(4);
    rdchk(3, 16'h0001, "R4 full after capture");
    rdchk(2, 16'h1234, "R4 captured value");
    rdchk(3, 16'h0000, "R10 full cleared by read");

    // R4 falling edge ignored with rising select
    evt_in[0] = 1'b0;
    tick(5);
    rdchk(3, 16'h0000, "R4 falling ignored");

    // R7 both edges on ch1, second arrival overruns
    tmr[2] = 16'h0777;
    wr(4, 16'h0039);
    evt_in[1] = 1'b1;
    expect_irq(1, 3);
    tick(4);
    tmr[2] = 16'h0888;
    evt_in[1] = 1'b0;
    expect_irq(1, 3);
    tick(4);
    rdchk(7, 16'h0003, "R7 overrun status");
    rdchk(6, 16'h0777, "R7 older value kept");
    rdchk(7, 16'h0000, "R10 status cleared");

    // R3 compare set on ch0 with timer0
    tmr[0] = 16'd10;
    wr(0, 16'h0043);
    wr(1, 16'd50);
    rdchk(3, 16'h0004, "R8 armed by write");
    tmr[0] = 16'd50;
    expect_irq(0, 1);
    tick(1);
    tmr[0] = 16'd51;
    chk("R3 set action", evt_out[0], 1'b1);
    rdchk(3, 16'h0000, "R8 disarmed after fire");
    tmr[0] = 16'd50;
    tick(2);
    tmr[0] = 16'd51;
    chk("R8 no second fire", evt_out[0], 1'b1);

    // R8 re-arm with toggle on ch1, timer3
    tmr[3] = 16'h0020;
    wr(4, 16'h01CF);
    wr(5, 16'h0040);
    tmr[3] = 16'h0040;
    expect_irq(1, 1);
    expect_irq(1, 2);
    expect_irq(1, 3);
    tick(1);
    chk("R3 toggle once", evt_out[1], 1'b1);
    tick(2);
    tmr[3] = 16'h0041;
    chk("R8 rearm toggled thrice", evt_out[1], 1'b1);

    // R3 clear action on ch0
    wr(0, 16'h0083);
    wr(1, 16'd60);
    tmr[0] = 16'd60;
    expect_irq(0, 1);
    tick(1);
    tmr[0] = 16'd61;
    chk("R3 clear action", evt_out[0], 1'b0);

    // R6 and R9: compare-only ch2 with mode bit 0, second capture of timer2
    tmr[2] = 16'h0ABC;
    tmr[0] = 16'h0071;
    wr(8, 16'h0C41);
    wr(9, 16'h0070);
    tmr[0] = 16'h0070;
    expect_irq(2, 1);
    tick(1);
    tmr[2] = 16'h0DEF;
    tmr[0] = 16'h0071;
    chk("R9 compare-only fires", evt_out[2], 1'b1);
    rdchk(10, 16'h0ABC, "R6 second timer captured");

    // R6 same timer selection stores nothing
    wr(12, 16'h0AC5);
    wr(13, 16'h0030);
    tmr[1] = 16'h0030;
    expect_irq(3, 1);
    tick(1);
    tmr[1] = 16'h0031;
    chk("R3 toggle ch3", evt_out[3], 1'b1);
    rdchk(15, 16'h0000, "R6 no capture when equal select");

    // R11 disabled compare channel
    wr(8, 16'h0C40);
    wr(9, 16'h0090);
    tmr[0] = 16'h0090;
    tick(3);
    tmr[0] = 16'h0091;
    chk("R11 pin unchanged", evt_out[2], 1'b1);
    rdchk(11, 16'h0004, "R11 still armed");

    // R11 disabled capture channel
    wr(0, 16'h0014);
    evt_in[0] = 1'b1;
    tick(5);
    rdchk(3, 16'h0000, "R11 no capture");

    tick(3);
    chk("R5 pending events", exp_ch.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule